// File: doc/BRIEF.md
# I2C Register-Access Target

This block is the serial front end of a small register bank. It watches an I2C bus through oversampled SCL and SDA inputs, recognises its own control byte, and turns the transfers that follow into single-cycle accesses on a plain register bus: an address, a write strobe with write data, and a read data input that the surrounding logic drives from the addressed register. The register bank itself is outside the block; the target owns only the bus protocol and the internal address pointer.

A write transfer carries a control byte, a register address byte and any number of data bytes. A read transfer writes the register address in the same way, then uses a repeated START and a control byte with the read bit set, after which the target returns register contents until the host declines a byte. The pointer either advances after every byte (sequential mode, the reset default) or stays put (byte mode). The mode is taken from one bit of the configuration register, which the block snoops from its own write strobes, so no extra input is needed.

The block is clocked by a system clock much faster than SCL. It never stretches SCL and drives SDA only as an open-drain pull-down enable.

Top module: `i2c_regport_target`

## Requirements
- R1: After reset the SDA pull-down is released, no write strobe is asserted, the pointer is 00h and the pointer mode is sequential.
- R2: A control byte is acknowledged only when its bits 7:4 equal the DEV_ID parameter (default 0100b) and bits 3:1 equal the latched hardware address; bit 0 is the read/write flag (1 = read). A control byte that does not match is not acknowledged and the rest of that transfer is ignored until the next START or STOP.
- R3: The hardware address input is sampled on the first clock after reset is released; later changes of that input have no effect.
- R4: A register address byte below 0Bh is acknowledged and loads the pointer; a value of 0Bh or more is not acknowledged, leaves the pointer alone and makes the target ignore the rest of the transfer.
- R5: Each data byte of a write transfer is acknowledged and produces exactly one single-cycle write strobe carrying the current pointer and the received byte.
- R6: In sequential mode the pointer advances by one after each acknowledged write data byte and after each read byte the host acknowledges, and advances from 0Ah to 00h.
- R7: Writing register 05h with bit 5 set selects byte mode, in which the pointer never advances, so repeated data bytes in one transfer reach the same register; writing 05h with bit 5 clear restores sequential mode. The new mode governs the pointer update that follows that same byte.
- R8: Register 08h is read-only: a data byte aimed at it is acknowledged and advances the pointer as usual, but raises no write strobe.
- R9: A STOP or repeated START that arrives before the eighth bit of a data byte discards that byte: no write strobe, and the pointer keeps its value.
- R10: In a read the target shifts the pointed register out MSB first, changing SDA only while SCL is low; when the host does not acknowledge a byte the target releases SDA and stays off the bus until the next START or STOP.
- R11: A STOP returns the target to idle with SDA released, and a repeated START at any point begins a new control byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| hw_addr_i | input | 3 | Hardware address select, sampled once after reset |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_addr_o | output | AW (4) | Register pointer, also the read address |
| reg_wr_o | output | 1 | Single-cycle write strobe |
| reg_wdata_o | output | 8 | Write data that goes with the strobe |
| reg_rdata_i | input | 8 | Contents of the register at reg_addr_o |

## Verification
The assertions take for granted a well-behaved host: SDA changes only while SCL is low except to form START and STOP, each SCL phase lasts well beyond the synchroniser latency, and the host never drives SDA low in a slot the target owns. Under those conditions the target's pull-down may only change while SCL is low, which the bench's stimulus respects by moving one line at a time and waiting a fixed eight clock cycles between moves. The bench sweeps all eight hardware addresses, walks the pointer around the full register space in both directions to cross the wrap point, and cuts data bytes short with both STOP and repeated START to confirm that nothing partial reaches the register bus.

// File: rtl/i2c_tgt_pkg.sv
// Shared types for the I2C register-access target.
// Assumes: nothing beyond IEEE 1800-2017.
package i2c_tgt_pkg;

    // Protocol position of the target.
    typedef enum logic [2:0] {
        ST_IDLE,   // no transfer addressed to this target
        ST_RX,     // shifting a byte in from the host
        ST_RACK,   // target acknowledge slot
        ST_TX,     // shifting a byte out to the host
        ST_HACK,   // host acknowledge slot after a read byte
        ST_SKIP    // off the bus until START or STOP
    } tgt_state_e;

    // Meaning of the byte being received.
    typedef enum logic [1:0] {
        PH_CTRL,
        PH_ADDR,
        PH_DATA
    } rx_phase_e;

endpackage

// File: rtl/i2c_line_sync.sv
// Brings SCL and SDA into the clock domain and reports bus events.
// Assumes: both lines are idle high at reset and each SCL phase lasts
// several clock cycles longer than the synchroniser depth.
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;

    // Synchronise both lines and keep the previous synchronised value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_d    <= scl_pipe[STAGES-1];
            sda_d    <= sda_pipe[STAGES-1];
        end
    end

    // Decode edges and conditions from the current and previous samples.
    always_comb begin
        scl_s     = scl_pipe[STAGES-1];
        sda_s     = sda_pipe[STAGES-1];
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        start_det = scl_s & scl_d & sda_d & ~sda_s;
        stop_det  = scl_s & scl_d & ~sda_d & sda_s;
    end

endmodule

// File: rtl/i2c_addr_ptr.sv
// Register pointer with load, conditional increment and wrap, plus the
// shadow of the pointer-mode bit snooped from configuration writes.
// Assumes: load and inc are never raised in the same cycle.
module i2c_addr_ptr #(
    parameter int NREG = 11,
    parameter int AW   = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          inc,
    input  logic          cfg_wr,
    input  logic          cfg_bit,
    output logic [AW-1:0] ptr,
    output logic          byte_mode
);

    localparam logic [AW-1:0] LAST = AW'(NREG - 1);

    // Pointer: load from an address byte or step with wrap when sequential.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= load_val;
        end else if (inc && !byte_mode) begin
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end

    // Mode shadow: follows the selected bit of every configuration write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_mode <= 1'b0;
        end else if (cfg_wr) begin
            byte_mode <= cfg_bit;
        end
    end

endmodule

// File: rtl/i2c_regport_target.sv
// I2C target that maps bus transfers onto a single-cycle register port.
// Control byte = {DEV_ID, hardware address, R/W}; then a register address
// byte; then data. Writes are committed at the eighth rising SCL edge of a
// data byte; the pointer moves at the end of the following ACK slot.
// Assumes: reg_rdata_i reflects reg_addr_o combinationally or within a few
// cycles; SCL is slow relative to clk; no clock stretching is required.
module i2c_regport_target
    import i2c_tgt_pkg::*;
#(
    parameter int          NREG        = 11,
    parameter logic [3:0]  DEV_ID      = 4'b0100,
    parameter int          RO_ADDR     = 8,
    parameter int          CFG_ADDR    = 5,
    parameter int          MODE_BIT    = 5,
    parameter int          SYNC_STAGES = 2,
    localparam int         AW          = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    input  logic [2:0]    hw_addr_i,
    output logic          sda_oe_o,
    output logic [AW-1:0] reg_addr_o,
    output logic          reg_wr_o,
    output logic [7:0]    reg_wdata_o,
    input  logic [7:0]    reg_rdata_i
);

    localparam logic [AW-1:0] RO_PTR  = AW'(RO_ADDR);
    localparam logic [AW-1:0] CFG_PTR = AW'(CFG_ADDR);
    localparam logic [7:0]    LIMIT   = 8'(NREG);

    logic          scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic          hw_valid;
    logic [2:0]    hw_lat;
    tgt_state_e    st;
    rx_phase_e     phase;
    logic [3:0]    bcnt;
    logic [6:0]    rx_sh;
    logic [6:0]    tx_sh;
    logic [7:0]    byte_nxt;
    logic          ack_en;
    logic          rd_req;
    logic          ptr_load;
    logic [AW-1:0] load_val;
    logic          ptr_inc;
    logic [AW-1:0] ptr;
    logic          byte_mode;
    logic          cfg_wr;
    logic          ctrl_match;
    logic          addr_ok;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    i2c_addr_ptr #(.NREG(NREG), .AW(AW)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ptr_load),
        .load_val (load_val),
        .inc      (ptr_inc),
        .cfg_wr   (cfg_wr),
        .cfg_bit  (reg_wdata_o[MODE_BIT]),
        .ptr      (ptr),
        .byte_mode(byte_mode)
    );

    // Hardware address: capture once on the first clock after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hw_valid <= 1'b0;
            hw_lat   <= '0;
        end else if (!hw_valid) begin
            hw_valid <= 1'b1;
            hw_lat   <= hw_addr_i;
        end
    end

    // Byte decode: the byte as it will stand after the current SCL rise.
    always_comb begin
        byte_nxt   = {rx_sh, sda_s};
        ctrl_match = (byte_nxt[7:1] == {DEV_ID, hw_lat});
        addr_ok    = (byte_nxt < LIMIT);
        cfg_wr     = reg_wr_o && (reg_addr_o == CFG_PTR);
        reg_addr_o = ptr;
    end

    // Protocol engine: bit counting, ACK slots, shifting and register strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= ST_IDLE;
            phase       <= PH_CTRL;
            bcnt        <= '0;
            rx_sh       <= '0;
            tx_sh       <= '0;
            ack_en      <= 1'b0;
            rd_req      <= 1'b0;
            sda_oe_o    <= 1'b0;
            reg_wr_o    <= 1'b0;
            reg_wdata_o <= '0;
            ptr_load    <= 1'b0;
            load_val    <= '0;
            ptr_inc     <= 1'b0;
        end else begin
            reg_wr_o <= 1'b0;
            ptr_load <= 1'b0;
            ptr_inc  <= 1'b0;
            if (start_det) begin
                st       <= ST_RX;
                phase    <= PH_CTRL;
                bcnt     <= '0;
                sda_oe_o <= 1'b0;
            end else if (stop_det) begin
                st       <= ST_IDLE;
                bcnt     <= '0;
                sda_oe_o <= 1'b0;
            end else begin
                case (st)
                    ST_RX: begin
                        if (scl_rise && bcnt < 4'd8) begin
                            rx_sh <= byte_nxt[6:0];
                            bcnt  <= bcnt + 1'b1;
                            if (bcnt == 4'd7) begin
                                case (phase)
                                    PH_CTRL: begin
                                        ack_en <= ctrl_match;
                                        rd_req <= byte_nxt[0];
                                    end
                                    PH_ADDR: begin
                                        ack_en   <= addr_ok;
                                        ptr_load <= addr_ok;
                                        load_val <= byte_nxt[AW-1:0];
                                    end
                                    default: begin
                                        ack_en      <= 1'b1;
                                        reg_wr_o    <= (ptr != RO_PTR);
                                        reg_wdata_o <= byte_nxt;
                                    end
                                endcase
                            end
                        end else if (scl_fall && bcnt == 4'd8) begin
                            if (ack_en) begin
                                st       <= ST_RACK;
                                sda_oe_o <= 1'b1;
                            end else begin
                                st <= ST_SKIP;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_fall) begin
                            sda_oe_o <= 1'b0;
                            bcnt     <= '0;
                            case (phase)
                                PH_CTRL: begin
                                    if (rd_req) begin
                                        tx_sh    <= reg_rdata_i[6:0];
                                        sda_oe_o <= ~reg_rdata_i[7];
                                        st       <= ST_TX;
                                    end else begin
                                        phase <= PH_ADDR;
                                        st    <= ST_RX;
                                    end
                                end
                                PH_ADDR: begin
                                    phase <= PH_DATA;
                                    st    <= ST_RX;
                                end
                                default: begin
                                    ptr_inc <= 1'b1;
                                    st      <= ST_RX;
                                end
                            endcase
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (bcnt == 4'd7) begin
                                sda_oe_o <= 1'b0;
                                bcnt     <= '0;
                                st       <= ST_HACK;
                            end else begin
                                sda_oe_o <= ~tx_sh[6];
                                tx_sh    <= {tx_sh[5:0], 1'b0};
                                bcnt     <= bcnt + 1'b1;
                            end
                        end
                    end
                    ST_HACK: begin
                        if (scl_rise) begin
                            if (sda_s) begin
                                st <= ST_SKIP;
                            end else begin
                                ptr_inc <= 1'b1;
                            end
                        end else if (scl_fall) begin
                            tx_sh    <= reg_rdata_i[6:0];
                            sda_oe_o <= ~reg_rdata_i[7];
                            bcnt     <= '0;
                            st       <= ST_TX;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_regport_target_chk.sv
// Checker for the I2C register-access target, bound into every instance.
// Assumes: the host obeys the bus rules listed in the brief.
module i2c_regport_target_chk #(
    parameter int NREG    = 11,
    parameter int RO_ADDR = 8,
    parameter int AW      = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_s,
    input logic          scl_rise,
    input logic          stop_det,
    input logic          sda_oe_o,
    input logic          reg_wr_o,
    input logic [AW-1:0] reg_addr_o,
    input logic          ptr_load,
    input logic          hw_valid,
    input logic [2:0]    hw_lat
);

    logic          armed;
    logic [AW-1:0] prev_addr;
    logic          prev_load;
    logic [AW-1:0] prev_next;

    // History of the pointer and its load request for the step check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed     <= 1'b0;
            prev_addr <= '0;
            prev_load <= 1'b0;
        end else begin
            armed     <= 1'b1;
            prev_addr <= reg_addr_o;
            prev_load <= ptr_load;
        end
    end

    // Expected successor of the previous pointer value.
    always_comb begin
        prev_next = (prev_addr == AW'(NREG - 1)) ? '0 : prev_addr + 1'b1;
    end

    AST_SDA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s)) |-> $stable(sda_oe_o));                         // R10
    AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_o |=> !reg_wr_o);                                                // R5
    AST_WR_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_o |-> $past(scl_rise));                                          // R9
    AST_NO_RO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_o |-> (int'(reg_addr_o) != RO_ADDR));                            // R8
    AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(reg_addr_o) < NREG);                                               // R4
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && reg_addr_o != prev_addr && !prev_load) |-> reg_addr_o == prev_next); // R6
    AST_HWADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_valid && $past(hw_valid)) |-> $stable(hw_lat));                     // R3
    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe_o);                                                // R11

endmodule

bind i2c_regport_target i2c_regport_target_chk #(
    .NREG   (NREG),
    .RO_ADDR(RO_ADDR),
    .AW     (AW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .scl_rise  (scl_rise),
    .stop_det  (stop_det),
    .sda_oe_o  (sda_oe_o),
    .reg_wr_o  (reg_wr_o),
    .reg_addr_o(reg_addr_o),
    .ptr_load  (ptr_load),
    .hw_valid  (hw_valid),
    .hw_lat    (hw_lat)
);

// File: tb/i2c_regport_target_tb.sv
// Self-checking bench: a bit-level I2C host, a register bank on the port,
// and an expected-value model of the pointer and register contents.
module i2c_regport_target_tb;

    localparam int NREG = 11;
    localparam int AW   = 4;
    localparam int Q    = 8;
    localparam logic [7:0] CW = 8'h4A;   // {0100, 101, write}
    localparam logic [7:0] CR = 8'h4B;   // {0100, 101, read}

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          scl_h = 1'b1;
    logic          sda_h = 1'b1;
    logic [2:0]    hw = 3'd5;
    logic          sda_oe;
    logic [AW-1:0] reg_addr;
    logic          reg_wr;
    logic [7:0]    reg_wdata;
    logic [7:0]    reg_rdata;
    logic          sda_line;
    logic [7:0]    mem [NREG];
    logic [7:0]    exp_m [NREG];
    int            wr_cnt;
    int            exp_ptr;
    bit            exp_byte;
    int            n_chk = 0;
    int            n_err = 0;
    bit            done = 0;

    always #2 clk = ~clk;

    assign sda_line  = sda_h & ~sda_oe;
    assign reg_rdata = (int'(reg_addr) < NREG) ? mem[reg_addr] : 8'h00;

    i2c_regport_target u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_h),
        .sda_i      (sda_line),
        .hw_addr_i  (hw),
        .sda_oe_o   (sda_oe),
        .reg_addr_o (reg_addr),
        .reg_wr_o   (reg_wr),
        .reg_wdata_o(reg_wdata),
        .reg_rdata_i(reg_rdata)
    );

    function automatic logic [7:0] init_val(int i);
        return 8'h80 + 8'(i * 5);
    endfunction

    // Register bank and strobe counter on the port.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) mem[i] <= init_val(i);
            wr_cnt <= 0;
        end else if (reg_wr) begin
            if (int'(reg_addr) < NREG) mem[reg_addr] <= reg_wdata;
            wr_cnt <= wr_cnt + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    function automatic void exp_adv();
        if (!exp_byte) exp_ptr = (exp_ptr == NREG - 1) ? 0 : exp_ptr + 1;
    endfunction

    function automatic void exp_commit(input logic [7:0] d);
        if (exp_ptr != 8) exp_m[exp_ptr] = d;
        if (exp_ptr == 5) exp_byte = d[5];
        exp_adv();
    endfunction

    task automatic qw();
        repeat (Q) @(posedge clk);
        #1;
    endtask

    task automatic h_start();
        sda_h = 1'b1; qw();
        scl_h = 1'b1; qw();
        sda_h = 1'b0; qw();
        scl_h = 1'b0; qw();
    endtask

    task automatic h_stop();
        sda_h = 1'b0; qw();
        scl_h = 1'b1; qw();
        sda_h = 1'b1; qw();
    endtask

    task automatic h_bit_w(input logic b);
        sda_h = b;    qw();
        scl_h = 1'b1; qw(); qw();
        scl_h = 1'b0; qw();
    endtask

    task automatic h_bit_r(output logic r);
        sda_h = 1'b1; qw();
        scl_h = 1'b1; qw();
        r = sda_line; qw();
        scl_h = 1'b0; qw();
    endtask

    task automatic h_wbyte(input logic [7:0] d, output bit ack);
        logic a;
        for (int i = 7; i >= 0; i--) h_bit_w(d[i]);
        h_bit_r(a);
        ack = !a;
    endtask

    task automatic h_rbyte(output logic [7:0] d, input bit host_ack);
        for (int i = 7; i >= 0; i--) h_bit_r(d[i]);
        h_bit_w(host_ack ? 1'b0 : 1'b1);
    endtask

    // Set the pointer, turn round with a repeated START and read n bytes.
    task automatic read_check(input int a, input int n, input string req);
        bit a1, a2, a3;
        logic [7:0] d;
        h_start();
        h_wbyte(CW, a1);
        h_wbyte(8'(a), a2);
        exp_ptr = a;
        h_start();
        h_wbyte(CR, a3);
        check(a1 && a2 && a3, {req, " acks"}, {a1, a2, a3}, 3'b111);
        for (int k = 0; k < n; k++) begin
            h_rbyte(d, k != n - 1);
            check(d == exp_m[exp_ptr], req, d, exp_m[exp_ptr]);
            if (k != n - 1) exp_adv();
        end
        h_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        bit ack, ack2;
        int c0;
        logic [7:0] d;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk);
        #1 hw = 3'd2;
        for (int i = 0; i < NREG; i++) exp_m[i] = init_val(i);
        exp_ptr  = 0;
        exp_byte = 0;

        // R1: reset state at the ports
        check(sda_oe == 1'b0, "R1 sda", sda_oe, 0);
        check(reg_wr == 1'b0, "R1 strobe", reg_wr, 0);
        check(reg_addr == '0, "R1 pointer", reg_addr, 0);

        // R2 and R3: sweep of the address field, input changed after latch
        for (int a = 0; a < 8; a++) begin
            h_start();
            h_wbyte({4'b0100, a[2:0], 1'b0}, ack);
            h_stop();
            check(ack == (a == 5), "R2 R3 address match", ack, (a == 5));
        end
        h_start();
        h_wbyte({4'b0110, 3'd5, 1'b0}, ack);
        c0 = wr_cnt;
        h_wbyte(8'h00, ack2);
        h_stop();
        check(!ack, "R2 device id", ack, 0);
        check(!ack2 && wr_cnt == c0, "R2 ignored remainder", {ack2, 8'(wr_cnt - c0)}, 0);

        // R5, R6, R8: sequential write over the wrap point
        h_start();
        h_wbyte(CW, ack);
        h_wbyte(8'h00, ack2);
        check(ack && ack2, "R5 header acks", {ack, ack2}, 2'b11);
        exp_ptr = 0;
        c0 = wr_cnt;
        for (int k = 0; k < 13; k++) begin
            d = 8'(k * 17 + 3) & 8'hDF;
            h_wbyte(d, ack);
            check(ack, "R5 data ack", ack, 1);
            exp_commit(d);
        end
        h_stop();
        check(wr_cnt - c0 == 12, "R8 strobe count", wr_cnt - c0, 12);
        check(sda_oe == 1'b0, "R11 released after stop", sda_oe, 0);
        read_check(0, 13, "R6 sequential readback");
        read_check(8, 1, "R8 read-only kept");

        // R4: address range
        read_check(10, 2, "R4 R6 last address and wrap");
        h_start();
        h_wbyte(CW, ack);
        h_wbyte(8'h0B, ack2);
        check(ack && !ack2, "R4 out of range nack", {ack, ack2}, 2'b10);
        c0 = wr_cnt;
        h_wbyte(8'h77, ack);
        h_stop();
        check(!ack && wr_cnt == c0, "R4 rest ignored", {ack, 8'(wr_cnt - c0)}, 0);

        // R7: byte mode on, repeated writes, then back to sequential
        h_start();
        h_wbyte(CW, ack);
        h_wbyte(8'h05, ack);
        exp_ptr = 5;
        h_wbyte(8'h20, ack);
        exp_commit(8'h20);
        h_stop();
        h_start();
        h_wbyte(CW, ack);
        h_wbyte(8'h02, ack);
        exp_ptr = 2;
        for (int k = 0; k < 3; k++) begin
            h_wbyte(8'h61 + 8'(k), ack);
            exp_commit(8'h61 + 8'(k));
        end
        h_stop();
        read_check(2, 3, "R7 byte mode hold");
        read_check(3, 1, "R7 neighbour untouched");
        h_start();
        h_wbyte(CW, ack);
        h_wbyte(8'h05, ack);
        exp_ptr = 5;
        h_wbyte(8'h00, ack);
        exp_commit(8'h00);
        h_wbyte(8'h5A, ack);
        exp_commit(8'h5A);
        h_stop();
        read_check(5, 2, "R7 sequential restored");

        // R9: partial byte cut by STOP
        c0 = wr_cnt;
        h_start();
        h_wbyte(CW, ack);
        h_wbyte(8'h03, ack);
        exp_ptr = 3;
        h_wbyte(8'h11, ack);
        exp_commit(8'h11);
        h_bit_w(1'b1); h_bit_w(1'b0); h_bit_w(1'b1); h_bit_w(1'b0);
        h_stop();
        check(wr_cnt == c0 + 1, "R9 stop discards", wr_cnt - c0, 1);
        read_check(3, 2, "R9 contents after stop");

        // R9 and R11: partial byte cut by repeated START, then read on
        c0 = wr_cnt;
        h_start();
        h_wbyte(CW, ack);
        h_wbyte(8'h09, ack);
        exp_ptr = 9;
        h_wbyte(8'h22, ack);
        exp_commit(8'h22);
        h_bit_w(1'b0); h_bit_w(1'b1); h_bit_w(1'b1);
        h_start();
        h_wbyte(CR, ack);
        check(ack, "R11 new control after restart", ack, 1);
        h_rbyte(d, 1'b0);
        check(d == exp_m[exp_ptr], "R9 pointer kept", d, exp_m[exp_ptr]);
        h_stop();
        check(wr_cnt == c0 + 1, "R9 restart discards", wr_cnt - c0, 1);

        // R10: release after host NACK
        h_start();
        h_wbyte(CR, ack);
        h_rbyte(d, 1'b0);
        check(d == exp_m[exp_ptr], "R10 current read", d, exp_m[exp_ptr]);
        h_rbyte(d, 1'b0);
        check(d == 8'hFF, "R10 bus released", d, 8'hFF);
        check(sda_oe == 1'b0, "R10 no drive", sda_oe, 0);
        h_stop();
        check(sda_oe == 1'b0, "R11 idle after stop", sda_oe, 0);

        done = 1;
        finish_run();
    end

endmodule